// File: doc/BRIEF.md
# Fast-Settling Sinc3 Decimation Front End

This block turns a 1-bit delta-sigma modulator stream into decimated conversion words and signals each new word with an active-low data-ready line. It runs on the modulator clock and takes one modulator bit per clock. After reset is released it discards the modulator bits for a fixed start-up interval. After that interval it feeds every bit to two filters in parallel. The first is a boxcar (sinc1) filter that settles within one output period. The second is a sinc3 decimator that needs three output periods of input before its result is valid.

The interim words come from the boxcar path, so the host gets usable data early. The first `FAST_WORDS` words (two by default) come from that path. The sinc3 path supplies every later word, and once the sinc3 path takes over, the boxcar path stops accumulating. Both paths produce the same unsigned density code on the same full scale, so the handover causes no gain step. The sequence restarts from the start-up interval whenever `rst` is asserted, whether the reset comes from a pin or from a command.

Top module: `fsfe_frontend`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to its initial state: `data_out` = 0, `drdy_n` = 1, `fast_active` = 1.
- R2: The modulator bits presented on the first `START_DELAY` clock edges after reset release (300 by default) do not affect any output word.
- R3: Let D = `DEC_RATIO`, where D must be a power of two. Counting the first edge with `rst` low as edge 0, word j (j ≥ 1) is registered at edge `START_DELAY + j*D - 1`. With the defaults, the first word appears on the 1324th edge and the first sinc3 word on the 3372nd. Between these edges, `data_out` holds its value.
- R4: Words 1 and 2 equal the number of ones among the D bits of their output period multiplied by D², as an unsigned value `3*log2(D)+1` bits wide.
- R5: Every word from the third on equals the sum of w[m]·x[n−m], where n is the index of the last bit of the period, x counts bits from the end of the start-up interval, and w[m] is the number of ways to write m as a+b+c with 0 ≤ a,b,c < D. The result is exact without overflow up to the full-scale value D³.
- R6: A constant input gives the same code from both paths: all zeros gives 0 and all ones gives D³.
- R7: `drdy_n` goes low on the edge that registers a word. If no read occurs, it returns high `RDY_HOLD` edges later.
- R8: If `rd_ack` is high at an edge where `drdy_n` is low and no new word is registered, `drdy_n` returns high at that edge. `rd_ack` has no effect while `drdy_n` is high. A new word takes precedence over `rd_ack` at the same edge.
- R9: `fast_active` stays 1 until word `FAST_WORDS+1` is registered. It falls to 0 at the edge that registers that word and stays 0 until reset.
- R10: A reset in the middle of the sequence restarts it completely: a new start-up interval, then boxcar words, then sinc3 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset (pin or command) |
| mod_bit | input | 1 | Modulator output bit, one per clock |
| rd_ack | input | 1 | Word-read indication; releases data-ready early |
| data_out | output | 3*log2(DEC_RATIO)+1 | Registered conversion word (unsigned density code) |
| drdy_n | output | 1 | Active-low data-ready |
| fast_active | output | 1 | High while the output word still comes from the boxcar path |

## Verification
The bench drives bits of value opposite to the main pattern during the start-up interval. A design that leaked those bits into either filter would give all-zero and all-one runs that miss 0 and full scale.

Every word is compared against a direct boxcar count or a direct triangular-weight convolution of the bits that were driven, computed in the bench. A design that handed over one word early or late, or that scaled one path differently from the other, would show a gain step or a settling error at the third word.

The bench checks `drdy_n` on every edge under three read behaviours: no read, a read one clock after the fall, and a read held high permanently. These runs expose an ignored read, a read that acts while the line is high, and a read that wins over a new word.

A reset issued just after the first word must restart the start-up interval. A design that kept its counters or integrator state across that reset would produce shifted or contaminated words.

// File: rtl/fsfe_pkg.sv
`timescale 1ns/1ps
package fsfe_pkg;
  typedef enum logic [0:0] {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  typedef enum logic [0:0] {
    SRC_FAST  = 1'b0,
    SRC_SINC3 = 1'b1
  } word_src_e;
endpackage

// File: rtl/fsfe_seq.sv
`timescale 1ns/1ps
module fsfe_seq
  import fsfe_pkg::*;
#(
  parameter int DEC_RATIO   = 1024,
  parameter int START_DELAY = 300,
  parameter int FAST_WORDS  = 2
) (
  input  logic      clk,
  input  logic      rst,
  output logic      sample_en,
  output logic      period_end,
  output word_src_e src
);
  localparam int L     = $clog2(DEC_RATIO);
  localparam int DLY_W = $clog2(START_DELAY + 1);
  localparam int WC_W  = $clog2(FAST_WORDS + 1);
  localparam logic [L-1:0]     PH_LAST  = L'(DEC_RATIO - 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(START_DELAY - 1);
  localparam logic [WC_W-1:0]  WC_MAX   = WC_W'(FAST_WORDS);

  seq_state_e       state;
  logic [DLY_W-1:0] dly_cnt;
  logic [L-1:0]     phase;
  logic [WC_W-1:0]  words_done;

  // Timebase: the start-up wait first, then the phase inside each output period
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_WAIT;
      dly_cnt    <= '0;
      phase      <= '0;
      words_done <= '0;
    end else if (state == ST_WAIT) begin
      if (dly_cnt == DLY_LAST) state <= ST_RUN;
      else dly_cnt <= dly_cnt + 1'b1;
    end else begin
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      if (phase == PH_LAST && words_done < WC_MAX)
        words_done <= words_done + 1'b1;
    end
  end

  assign sample_en  = (state == ST_RUN);
  assign period_end = sample_en && (phase == PH_LAST);
  assign src        = (words_done < WC_MAX) ? SRC_FAST : SRC_SINC3;

  // R3: sampling always starts at the beginning of an output period
  p_start_phase_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_en) |-> (phase == '0));
  // R9: once the sinc3 path owns the output, it keeps it
  p_src_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_SINC3) |=> (src == SRC_SINC3));
endmodule

// File: rtl/fsfe_boxcar.sv
`timescale 1ns/1ps
module fsfe_boxcar #(
  parameter int DEC_RATIO = 1024
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         bit_i,
  input  logic         last,
  output logic [$clog2(DEC_RATIO):0] sum_o
);
  localparam int L  = $clog2(DEC_RATIO);
  localparam int SW = L + 1;
  localparam logic [SW-1:0] FULL = SW'(DEC_RATIO);

  logic [SW-1:0] acc;

  assign sum_o = acc + {{(SW-1){1'b0}}, bit_i};

  // One-period accumulator, cleared at every period boundary
  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (en) acc <= last ? '0 : sum_o;
  end

  // R4: a one-period ones count can never exceed the decimation ratio
  p_box_range_r4: assert property (@(posedge clk) disable iff (rst)
    (en && last) |-> (sum_o <= FULL));
endmodule

// File: rtl/fsfe_cic3.sv
`timescale 1ns/1ps
module fsfe_cic3 #(
  parameter int DEC_RATIO = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bit_i,
  input  logic dump,
  output logic [3*$clog2(DEC_RATIO):0] result
);
  localparam int L  = $clog2(DEC_RATIO);
  localparam int CW = 3 * L + 1;
  localparam logic [CW-1:0] FULL = {{(CW-1){1'b0}}, 1'b1} << (3 * L);

  logic [CW-1:0] integ [3];
  logic [CW-1:0] integ_n [3];
  logic [CW-1:0] comb_d [3];
  logic [CW-1:0] comb_v [3];

  // Integrator cascade at the modulator rate; modulo arithmetic is exact at width CW
  assign integ_n[0] = integ[0] + {{(CW-1){1'b0}}, bit_i};
  for (genvar s = 1; s < 3; s++) begin : g_integ
    assign integ_n[s] = integ[s] + integ_n[s-1];
  end

  // Differentiator cascade at the output rate
  assign comb_v[0] = integ_n[2] - comb_d[0];
  for (genvar s = 1; s < 3; s++) begin : g_comb
    assign comb_v[s] = comb_v[s-1] - comb_d[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 3; s++) begin
        integ[s]  <= '0;
        comb_d[s] <= '0;
      end
    end else if (en) begin
      for (int s = 0; s < 3; s++) integ[s] <= integ_n[s];
      if (dump) begin
        comb_d[0] <= integ_n[2];
        comb_d[1] <= comb_v[0];
        comb_d[2] <= comb_v[1];
      end
    end
  end

  assign result = comb_v[2];

  // R5: the decimated sinc3 result stays within full scale (no wrap)
  p_sinc3_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (en && dump) |-> (result <= FULL));
endmodule

// File: rtl/fsfe_frontend.sv
`timescale 1ns/1ps
module fsfe_frontend
  import fsfe_pkg::*;
#(
  parameter int DEC_RATIO   = 1024,
  parameter int START_DELAY = 300,
  parameter int FAST_WORDS  = 2,
  parameter int RDY_HOLD    = 32,
  localparam int OUT_W      = 3 * $clog2(DEC_RATIO) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mod_bit,
  input  logic             rd_ack,
  output logic [OUT_W-1:0] data_out,
  output logic             drdy_n,
  output logic             fast_active
);
  localparam int L      = $clog2(DEC_RATIO);
  localparam int HOLD_W = $clog2(RDY_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RDY_HOLD - 1);

  logic             sample_en;
  logic             word_stb;
  word_src_e        src;
  logic [L:0]       box_sum;
  logic [OUT_W-1:0] sinc_word;
  logic [OUT_W-1:0] fast_word;
  logic [HOLD_W-1:0] hold_cnt;

  fsfe_seq #(
    .DEC_RATIO  (DEC_RATIO),
    .START_DELAY(START_DELAY),
    .FAST_WORDS (FAST_WORDS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .period_end(word_stb),
    .src       (src)
  );

  fsfe_boxcar #(.DEC_RATIO(DEC_RATIO)) u_fast (
    .clk  (clk),
    .rst  (rst),
    .en   (sample_en && (src == SRC_FAST)),
    .bit_i(mod_bit),
    .last (word_stb),
    .sum_o(box_sum)
  );

  fsfe_cic3 #(.DEC_RATIO(DEC_RATIO)) u_sinc3 (
    .clk   (clk),
    .rst   (rst),
    .en    (sample_en),
    .bit_i (mod_bit),
    .dump  (word_stb),
    .result(sinc_word)
  );

  // Bring the boxcar count onto the sinc3 full scale (gain D^3 vs D)
  assign fast_word = {box_sum, {(2 * L){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out    <= '0;
      drdy_n      <= 1'b1;
      hold_cnt    <= '0;
      fast_active <= 1'b1;
    end else if (word_stb) begin
      data_out    <= (src == SRC_FAST) ? fast_word : sinc_word;
      drdy_n      <= 1'b0;
      hold_cnt    <= '0;
      fast_active <= (src == SRC_FAST);
    end else if (!drdy_n) begin
      if (rd_ack || hold_cnt == HOLD_LAST) drdy_n <= 1'b1;
      else hold_cnt <= hold_cnt + 1'b1;
    end
  end

  // R3: the word only changes on a data-ready edge
  p_data_stable_r3: assert property (@(posedge clk) disable iff (rst)
    !word_stb |=> $stable(data_out));
  // R7: a new word always pulls data-ready low
  p_word_fall_r7: assert property (@(posedge clk) disable iff (rst)
    word_stb |=> !drdy_n);
  // R8: a read while low and without a new word releases data-ready
  p_ack_release_r8: assert property (@(posedge clk) disable iff (rst)
    (!drdy_n && rd_ack && !word_stb) |=> drdy_n);
  // R9: the fast-path flag never comes back without a reset
  p_flag_monotone_r9: assert property (@(posedge clk) disable iff (rst)
    !fast_active |=> !fast_active);
endmodule

// File: tb/fsfe_frontend_test.sv
`timescale 1ns/1ps
module fsfe_frontend_test;
  localparam int D     = 8;
  localparam int L     = 3;
  localparam int DLY   = 5;
  localparam int HOLD  = 3;
  localparam int FW    = 2;
  localparam int OUT_W = 3 * L + 1;
  localparam int FULL  = D * D * D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mod_bit = 1'b0;
  logic rd_ack = 1'b0;
  logic [OUT_W-1:0] data_out;
  logic drdy_n;
  logic fast_active;

  int nchk = 0;
  int nerr = 0;
  int w [0:3*D-3];
  int xs [0:255];

  always #5 clk = ~clk;

  fsfe_frontend #(
    .DEC_RATIO  (D),
    .START_DELAY(DLY),
    .FAST_WORDS (FW),
    .RDY_HOLD   (HOLD)
  ) uut (
    .clk        (clk),
    .rst        (rst),
    .mod_bit    (mod_bit),
    .rd_ack     (rd_ack),
    .data_out   (data_out),
    .drdy_n     (drdy_n),
    .fast_active(fast_active)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic gen(input int pat, input int n);
    case (pat)
      0: return 1'b0;
      1: return 1'b1;
      2: return n[0];
      3: return ((n * 37 + 11) % 13) < 6;
      default: return (n % 5) < 3;
    endcase
  endfunction

  function automatic int box_word(input int j);
    int s = 0;
    for (int i = (j - 1) * D; i < j * D; i++) s += xs[i];
    return s * D * D;
  endfunction

  function automatic int sinc_word(input int j);
    int s = 0;
    for (int m = 0; m <= 3 * D - 3; m++)
      if (j * D - 1 - m >= 0) s += w[m] * xs[j * D - 1 - m];
    return s;
  endfunction

  // ackm: 0 no read, 1 read one clock after each fall, 2 read held high
  task automatic run(input string rtag, input int pat, input int ackm, input int ncyc);
    int  j = 0;
    int  fall_k = -10;
    int  cnt = 0;
    int  exp_data = 0;
    bit  low = 1'b0;
    rst = 1'b1;
    rd_ack = 1'b0;
    mod_bit = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #2;
    chk({rtag, " data"}, int'(data_out), 0);
    chk({rtag, " drdy_n"}, int'(drdy_n), 1);
    chk({rtag, " fast_active"}, int'(fast_active), 1);
    rst = 1'b0;
    for (int k = 0; k < ncyc; k++) begin
      bit pe;
      if (k < DLY) mod_bit = (pat == 1) ? 1'b0 : 1'b1;
      else begin
        mod_bit = gen(pat, k - DLY);
        xs[k - DLY] = int'(mod_bit);
      end
      rd_ack = (ackm == 2) || (ackm == 1 && k == fall_k + 1);
      @(posedge clk);
      #2;
      pe = (k >= DLY) && ((k - DLY) % D == D - 1);
      if (pe) begin
        j++;
        low = 1'b1;
        cnt = 0;
        fall_k = k;
        exp_data = (j <= FW) ? box_word(j) : sinc_word(j);
        if (pat == 0) chk("R2 word", int'(data_out), exp_data);
        else if (pat == 1) chk("R6 word", int'(data_out), exp_data);
        else if (j <= FW) chk("R4 word", int'(data_out), exp_data);
        else chk("R5 word", int'(data_out), exp_data);
        if (j == 1 && rtag == "R10") chk("R10 restart word", int'(data_out), exp_data);
      end else if (low) begin
        if (rd_ack) low = 1'b0;
        else if (cnt == HOLD - 1) low = 1'b0;
        else cnt++;
      end
      chk("R3 data hold", int'(data_out), exp_data);
      if (ackm != 0) chk("R8 drdy_n", int'(drdy_n), int'(!low));
      else chk("R7 drdy_n", int'(drdy_n), int'(!low));
      chk("R9 fast_active", int'(fast_active), (j <= FW) ? 1 : 0);
    end
    rd_ack = 1'b0;
  endtask

  initial begin
    for (int m = 0; m <= 3 * D - 3; m++) w[m] = 0;
    for (int a = 0; a < D; a++)
      for (int b = 0; b < D; b++)
        for (int c = 0; c < D; c++) w[a + b + c]++;
    for (int i = 0; i < 256; i++) xs[i] = 0;

    run("R1", 0, 0, DLY + 5 * D + 2);
    run("R1", 1, 2, DLY + 5 * D + 2);
    chk("R6 full scale", int'(data_out), FULL);
    run("R1", 2, 1, DLY + 6 * D + 2);
    run("R1", 3, 0, DLY + D + 3);
    run("R10", 3, 1, DLY + 6 * D + 2);
    run("R1", 4, 2, DLY + 6 * D + 4);
    run("R1", 4, 0, DLY + 6 * D + 4);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    #2000000;
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule